// File: doc/BRIEF.md
# Load-Use Interlock Unit

This unit sits in the decode stage of a five-stage in-order pipeline. Each cycle it compares the source register fields of the instruction in decode with the destination of the instruction in execute. If the instruction in execute is a load, forwarding cannot bring its data back in time for a consumer that follows it directly. The load's data only exists after the memory stage.

When such a dependence is found, the unit freezes the program counter and the IF/ID register for one cycle. It also tells the ID/EX register to take a no-op bubble, with all of its write and memory enables cleared, in place of the decoded instruction. The bubble then moves down the pipe, and on the next cycle the consumer gets the load data through the normal forwarding paths. Consumers two or more slots behind the load never stall. Detection is combinational, and the enables act at the next clock edge.

Top module: `load_use_interlock`

## Requirements
- R1: When `ex_is_load` is 1, `ex_dest` is nonzero, and a decode source whose `dec_src_used` bit is 1 equals `ex_dest`, the unit drives `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1 in that same cycle.
- R2: When `ex_is_load` is 0, the unit never stalls, even if a used source equals `ex_dest`.
- R3: A source field whose `dec_src_used` bit is 0 never causes a stall, even if it equals the load destination. The bit alone decides, so a store's data source that is marked used does stall.
- R4: A load whose destination is register 0 never causes a stall.
- R5: Any source slot can raise the hazard. Source slot k occupies bits [k*5+4:k*5] of `dec_src_idx`, and both slot 0 and slot 1 must trigger.
- R6: In the cycle after a stall the unit does not stall again, even if the execute-stage inputs still show the same load. Each load therefore inserts exactly one bubble.
- R7: In every cycle, `pc_we` equals `ifid_we`, and `idex_bubble` is their inverse.
- R8: While `rst_n` is 0 the unit does not stall (`pc_we`=1, `ifid_we`=1, `idex_bubble`=0), and the one-bubble memory is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the pipeline registers |
| rst_n | input | 1 | Active-low reset |
| dec_src_idx | input | 10 | Decode-stage source register numbers, 5 bits per slot |
| dec_src_used | input | 2 | Per-slot flag: the decode instruction reads this source |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_dest | input | 5 | Destination register of the instruction in execute |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | IF/ID register write enable |
| idex_bubble | output | 1 | Load a no-op into ID/EX instead of the decoded instruction |

## Verification
Two functions can meet in the same cycle: detecting a fresh hazard, and suppressing a second bubble for the load that has just been stalled on. The bench provokes this by holding the load and a matching consumer on the inputs across a clock edge. It expects a stall in the first cycle and free-running enables in the second. A separate case removes and then reapplies the hazard, to confirm that suppression lasts only the one cycle after a stall and does not block a later, genuine load-use pair.

// File: rtl/lui_pkg.sv
package lui_pkg;

   typedef enum logic [0:0] {
      PIPE_FLOW = 1'b0,
      PIPE_HOLD = 1'b1
   } pipe_act_e;

   localparam int LUI_DEF_REG_AW  = 5;
   localparam int LUI_DEF_NUM_SRC = 2;

endpackage

// File: rtl/lui_src_match.sv
module lui_src_match #(
   parameter int REG_AW    = 5,
   parameter bit ZERO_SKIP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] src_idx,
   input  logic              src_used,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] ex_dest,
   output logic              hit
);

   logic same_reg;
   logic dest_live;

   assign same_reg = (src_idx == ex_dest);

   generate
      if (ZERO_SKIP) begin : g_zero_skip
         assign dest_live = |ex_dest;
      end else begin : g_zero_real
         assign dest_live = 1'b1;
      end
   endgenerate

   assign hit = ex_load & src_used & dest_live & same_reg;

   // R3
   unused_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_used |-> !hit);

   // R2
   nonload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_load |-> !hit);

endmodule

// File: rtl/lui_stall_ctrl.sv
module lui_stall_ctrl
   import lui_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic any_hit,
   output logic pc_we,
   output logic ifid_we,
   output logic idex_bubble
);

   pipe_act_e act;
   logic      held_q;

   always_comb begin
      act = PIPE_FLOW;
      if (rst_n && any_hit && !held_q) act = PIPE_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= (act == PIPE_HOLD);
   end

   assign pc_we       = (act == PIPE_FLOW);
   assign ifid_we     = (act == PIPE_FLOW);
   assign idex_bubble = (act == PIPE_HOLD);

   // R6
   single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idex_bubble |=> !idex_bubble);

endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
   import lui_pkg::*;
#(
   parameter int REG_AW    = LUI_DEF_REG_AW,
   parameter int NUM_SRC   = LUI_DEF_NUM_SRC,
   parameter bit ZERO_SKIP = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC*REG_AW-1:0] dec_src_idx,
   input  logic [NUM_SRC-1:0]        dec_src_used,
   input  logic                      ex_is_load,
   input  logic [REG_AW-1:0]         ex_dest,
   output logic                      pc_we,
   output logic                      ifid_we,
   output logic                      idex_bubble
);

   localparam int IDX_W = NUM_SRC * REG_AW;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("load_use_interlock: REG_AW out of range");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
         $error("load_use_interlock: NUM_SRC out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] slot_hit;

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
         lui_src_match #(
            .REG_AW   (REG_AW),
            .ZERO_SKIP(ZERO_SKIP)
         ) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_idx (dec_src_idx[k*REG_AW +: REG_AW]),
            .src_used(dec_src_used[k]),
            .ex_load (ex_is_load),
            .ex_dest (ex_dest),
            .hit     (slot_hit[k])
         );
      end
   endgenerate

   lui_stall_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .any_hit    (|slot_hit),
      .pc_we      (pc_we),
      .ifid_we    (ifid_we),
      .idex_bubble(idex_bubble)
   );

   // R7
   enables_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we == ifid_we) && (idex_bubble == !pc_we));

   // R4
   zero_dest_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_SKIP && ex_dest == '0) |-> !idex_bubble);

   // R1
   bubble_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idex_bubble |-> (ex_is_load && (|dec_src_used)));

   logic [IDX_W-1:0] unused_width_probe;
   assign unused_width_probe = dec_src_idx;

endmodule

// File: tb/load_use_interlock_bench.sv
module load_use_interlock_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] dec_src_idx = '0;
   logic [1:0] dec_src_used = '0;
   logic       ex_is_load = 1'b0;
   logic [4:0] ex_dest = '0;
   logic       pc_we, ifid_we, idex_bubble;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #5 clk = ~clk;

   load_use_interlock u_load_use_interlock (
      .clk(clk), .rst_n(rst_n), .dec_src_idx(dec_src_idx),
      .dec_src_used(dec_src_used), .ex_is_load(ex_is_load),
      .ex_dest(ex_dest), .pc_we(pc_we), .ifid_we(ifid_we),
      .idex_bubble(idex_bubble));

   task automatic expect_stall(input string req, input bit exp);
      n_tests++;
      if (pc_we !== !exp || ifid_we !== !exp || idex_bubble !== exp) begin
         n_fail++;
         $display("FAIL %s: pc_we=%b ifid_we=%b bubble=%b expected pc_we=%b ifid_we=%b bubble=%b",
                  req, pc_we, ifid_we, idex_bubble, !exp, !exp, exp);
      end
   endtask

   task automatic drive(input logic [4:0] s0, input logic [4:0] s1,
                        input logic [1:0] used, input logic ld, input logic [4:0] d);
      @(negedge clk);
      dec_src_idx  = {s1, s0};
      dec_src_used = used;
      ex_is_load   = ld;
      ex_dest      = d;
      #1;
   endtask

   task automatic idle();
      drive(5'd0, 5'd0, 2'b00, 1'b0, 5'd0);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      drive(5'd3, 5'd4, 2'b11, 1'b1, 5'd3);
      expect_stall("R8 no stall in reset", 1'b0);
      @(negedge clk); rst_n = 1'b1;
      idle();
      expect_stall("R8 idle after reset", 1'b0);
   endtask

   task automatic t_basic();
      drive(5'd7, 5'd2, 2'b11, 1'b1, 5'd7);
      expect_stall("R1 slot0 hazard", 1'b1);
      idle();
      drive(5'd1, 5'd9, 2'b11, 1'b1, 5'd9);
      expect_stall("R5 slot1 hazard", 1'b1);
      idle();
      drive(5'd1, 5'd9, 2'b11, 1'b1, 5'd10);
      expect_stall("R1 no match no stall", 1'b0);
      idle();
   endtask

   task automatic t_nonload();
      drive(5'd6, 5'd6, 2'b11, 1'b0, 5'd6);
      expect_stall("R2 non-load producer", 1'b0);
      idle();
   endtask

   task automatic t_used();
      drive(5'd12, 5'd3, 2'b10, 1'b1, 5'd12);
      expect_stall("R3 unused slot0", 1'b0);
      idle();
      drive(5'd3, 5'd12, 2'b01, 1'b1, 5'd12);
      expect_stall("R3 unused slot1", 1'b0);
      idle();
      drive(5'd3, 5'd12, 2'b10, 1'b1, 5'd12);
      expect_stall("R3 store data source used", 1'b1);
      idle();
   endtask

   task automatic t_zero();
      drive(5'd0, 5'd0, 2'b11, 1'b1, 5'd0);
      expect_stall("R4 dest r0", 1'b0);
      idle();
   endtask

   task automatic t_one_bubble();
      drive(5'd15, 5'd15, 2'b11, 1'b1, 5'd15);
      expect_stall("R6 first cycle stalls", 1'b1);
      @(negedge clk); #1;
      expect_stall("R6 second cycle flows", 1'b0);
      @(negedge clk); #1;
      expect_stall("R6 fresh hazard after release", 1'b1);
      idle();
      drive(5'd15, 5'd15, 2'b11, 1'b1, 5'd15);
      expect_stall("R6 reapplied hazard stalls", 1'b1);
      idle();
   endtask

   task automatic t_consistency();
      for (int i = 0; i < 32; i++) begin
         drive(5'(i), 5'(31 - i), 2'(i % 4), 1'(i % 2), 5'(i % 8));
         n_tests++;
         if (pc_we !== ifid_we || idex_bubble !== !pc_we) begin
            n_fail++;
            $display("FAIL R7: pc_we=%b ifid_we=%b bubble=%b expected agreeing enables",
                     pc_we, ifid_we, idex_bubble);
         end
         idle();
      end
   endtask

   initial begin
      t_reset();
      t_basic();
      t_nonload();
      t_used();
      t_zero();
      t_one_bubble();
      t_consistency();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule